// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block records loads that a scheduler has hoisted above stores whose addresses were unknown when the load issued. Each hoisted load writes an entry. The entry is keyed by the load's destination register and holds the byte range that the load read. Every store that goes by is compared against all entries. Any entry whose byte range shares even one byte with the store is dropped.

When the original program position of the load is reached, a check operation looks the register up. A hit means the speculative value is still good. A miss means the value must be rebuilt. A check of the load flavour asks for the load to be issued again. A check of the branch flavour asks for a jump to recovery code.

The table is fully associative and its default size is sixteen entries. A lookup is combinational. All updates take effect at the next clock edge. When every entry is in use, an entry is evicted in round-robin order. An evicted entry can only ever make a later check miss; it can never make a check hit falsely. A flush input empties the table in one cycle, for example on a context switch.

Top module: `spec_load_table`

## Requirements
- R1: After reset every entry is invalid, so every check misses until a load is recorded.
- R2: A recorded load (ld_valid=1 while flush_all=0) makes a check of the same register hit from the following cycle on.
- R3: chk_branch=0 selects a load-flavour check and chk_branch=1 a branch-flavour check. On a miss, a load-flavour check raises chk_reissue only and a branch-flavour check raises chk_recover only. On a hit neither is raised. While chk_valid=0, chk_hit, chk_reissue and chk_recover are all 0.
- R4: At most one valid entry exists per register. Recording a load to a register already present overwrites that entry, so only the newest address range applies.
- R5: Size codes 0, 1, 2, 3 mean 1, 2, 4, 8 bytes. A store drops every entry whose range [addr, addr+bytes) intersects the store's range. Ranges that only touch end to end do not intersect, and ranges do not wrap past the top of the address space.
- R6: When a store and a recorded load occur in the same cycle, the store's kills are applied first and then the new entry is written, so the new entry survives even if it overlaps the store.
- R7: The slot for a new entry is chosen as follows: the entry already holding the same register; otherwise the lowest-index free entry; otherwise the entry at a round-robin pointer. The pointer starts at index 0 and advances by one (wrapping) only when it is used for eviction. An evicted register then misses.
- R8: A load-flavour hit leaves the entry valid whatever the value of chk_clear. A branch-flavour hit with chk_clear=1 drops the entry from the next cycle on. With chk_clear=0 the entry is kept.
- R9: flush_all=1 leaves every entry invalid in the next cycle. A load recorded in the same cycle is discarded and the round-robin pointer does not move.
- R10: A check sees the table as it stood before the current cycle's updates, so a load recorded in a cycle is not visible to a check in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_all | input | 1 | Invalidate every entry |
| ld_valid | input | 1 | Record a hoisted load this cycle |
| ld_reg | input | REG_W (7) | Destination register of the hoisted load |
| ld_addr | input | ADDR_W (64) | Byte address of the hoisted load |
| ld_size | input | 2 | Size code of the hoisted load |
| st_valid | input | 1 | A store is being snooped |
| st_addr | input | ADDR_W (64) | Byte address of the store |
| st_size | input | 2 | Size code of the store |
| chk_valid | input | 1 | A check lookup is requested |
| chk_reg | input | REG_W (7) | Register looked up by the check |
| chk_branch | input | 1 | 0 = load-flavour check, 1 = branch-flavour check |
| chk_clear | input | 1 | On a branch-flavour hit, drop the entry |
| chk_hit | output | 1 | Lookup found a valid entry |
| chk_reissue | output | 1 | Load-flavour miss: issue the load again |
| chk_recover | output | 1 | Branch-flavour miss: branch to recovery |

## Verification
The bench builds the block with its default parameters: sixteen entries, 7-bit register tags and 64-bit addresses. Random traffic uses only 24 register values and addresses inside a 64-byte window. With so few registers, same-register overwrite, the capacity limit and round-robin eviction all occur often. With so narrow a window, stores that partly overlap an entry or only touch its edge occur often. Directed cases add the top-of-address-space edge, same-cycle load and store, flush with a concurrent load, and the clear-on-check choices.

// File: rtl/sltab_pkg.sv
package sltab_pkg;

  // Size code to byte count: 0->1, 1->2, 2->4, 3->8
  function automatic logic [3:0] span_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

endpackage

// File: rtl/sltab_cam.sv
module sltab_cam #(
  parameter int N      = 16,
  parameter int REG_W  = 7,
  parameter int ADDR_W = 64
) (
  input  logic [N-1:0]      v_vec,
  input  logic [REG_W-1:0]  reg_q  [N],
  input  logic [ADDR_W-1:0] addr_q [N],
  input  logic [1:0]        size_q [N],
  input  logic [REG_W-1:0]  chk_reg,
  input  logic [REG_W-1:0]  ld_reg,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  output logic [N-1:0]      chk_eq,
  output logic [N-1:0]      ld_eq,
  output logic [N-1:0]      st_ovl
);
  import sltab_pkg::*;

  localparam int EXT_W = ADDR_W + 1;

  // Half-open byte ranges compared one bit wider so the top never wraps
  function automatic logic ranges_meet(input logic [ADDR_W-1:0] a, input logic [1:0] sa,
                                       input logic [ADDR_W-1:0] b, input logic [1:0] sb);
    logic [EXT_W-1:0] a_lo, a_hi, b_lo, b_hi;
    a_lo = {1'b0, a};
    b_lo = {1'b0, b};
    a_hi = a_lo + {{(EXT_W-4){1'b0}}, span_bytes(sa)};
    b_hi = b_lo + {{(EXT_W-4){1'b0}}, span_bytes(sb)};
    return (a_lo < b_hi) && (b_lo < a_hi);
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_ent
    assign chk_eq[i] = v_vec[i] && (reg_q[i] == chk_reg);
    assign ld_eq[i]  = (reg_q[i] == ld_reg);
    assign st_ovl[i] = v_vec[i] && ranges_meet(addr_q[i], size_q[i], st_addr, st_size);
  end

endmodule

// File: rtl/sltab_victim.sv
module sltab_victim #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [N-1:0] same_vec,
  input  logic [N-1:0] free_vec,
  output logic [N-1:0] slot_vec,
  output logic         evict
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam logic [PW-1:0] LAST = PW'(N - 1);

  logic [PW-1:0] rr_ptr;

  function automatic logic [N-1:0] lowest_set(input logic [N-1:0] v);
    logic [N-1:0] r;
    r = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (v[k]) r = N'(1) << k;
    end
    return r;
  endfunction

  always_comb begin
    if (|same_vec)      slot_vec = lowest_set(same_vec);
    else if (|free_vec) slot_vec = lowest_set(free_vec);
    else                slot_vec = N'(1) << rr_ptr;
  end

  assign evict = go && !(|same_vec) && !(|free_vec);

  always_ff @(posedge clk) begin
    if (!rst_n)     rr_ptr <= '0;
    else if (evict) rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
  end

endmodule

// File: rtl/sltab_array.sv
module sltab_array #(
  parameter int N      = 16,
  parameter int REG_W  = 7,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [N-1:0]      kill_vec,
  input  logic [N-1:0]      wr_vec,
  input  logic [REG_W-1:0]  wr_reg,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_size,
  output logic [N-1:0]      v_vec,
  output logic [REG_W-1:0]  reg_q  [N],
  output logic [ADDR_W-1:0] addr_q [N],
  output logic [1:0]        size_q [N]
);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) v_vec <= '0;
    else                 v_vec <= (v_vec & ~kill_vec) | wr_vec;
  end

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        reg_q[i]  <= '0;
        addr_q[i] <= '0;
        size_q[i] <= '0;
      end else if (wr_vec[i]) begin
        reg_q[i]  <= wr_reg;
        addr_q[i] <= wr_addr;
        size_q[i] <= wr_size;
      end
    end
  end

endmodule

// File: rtl/spec_load_table.sv
module spec_load_table #(
  parameter int ENTRIES = 16,
  parameter int REG_W   = 7,
  parameter int ADDR_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_all,
  input  logic              ld_valid,
  input  logic [REG_W-1:0]  ld_reg,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [1:0]        ld_size,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  input  logic              chk_branch,
  input  logic              chk_clear,
  output logic              chk_hit,
  output logic              chk_reissue,
  output logic              chk_recover
);

  logic [ENTRIES-1:0] v_vec;
  logic [REG_W-1:0]   reg_q  [ENTRIES];
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [1:0]         size_q [ENTRIES];

  // Named internal events
  logic [ENTRIES-1:0] chk_eq, ld_eq, st_ovl;
  logic [ENTRIES-1:0] st_kill, clr_vec, kill_vec, live_vec;
  logic [ENTRIES-1:0] same_vec, free_vec, slot_vec, alloc_vec;
  logic               alloc_go, evict, any_match;

  sltab_cam #(.N(ENTRIES), .REG_W(REG_W), .ADDR_W(ADDR_W)) i_cam (
    .v_vec   (v_vec),
    .reg_q   (reg_q),
    .addr_q  (addr_q),
    .size_q  (size_q),
    .chk_reg (chk_reg),
    .ld_reg  (ld_reg),
    .st_addr (st_addr),
    .st_size (st_size),
    .chk_eq  (chk_eq),
    .ld_eq   (ld_eq),
    .st_ovl  (st_ovl)
  );

  assign any_match = |chk_eq;
  assign st_kill   = st_valid ? st_ovl : '0;
  assign clr_vec   = (chk_valid && chk_branch && chk_clear) ? chk_eq : '0;
  assign kill_vec  = st_kill | clr_vec;
  assign live_vec  = v_vec & ~kill_vec;
  assign alloc_go  = ld_valid && !flush_all;
  assign same_vec  = live_vec & ld_eq;
  assign free_vec  = ~live_vec;

  sltab_victim #(.N(ENTRIES)) i_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (alloc_go),
    .same_vec (same_vec),
    .free_vec (free_vec),
    .slot_vec (slot_vec),
    .evict    (evict)
  );

  assign alloc_vec = alloc_go ? slot_vec : '0;

  sltab_array #(.N(ENTRIES), .REG_W(REG_W), .ADDR_W(ADDR_W)) i_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush_all),
    .kill_vec (kill_vec),
    .wr_vec   (alloc_vec),
    .wr_reg   (ld_reg),
    .wr_addr  (ld_addr),
    .wr_size  (ld_size),
    .v_vec    (v_vec),
    .reg_q    (reg_q),
    .addr_q   (addr_q),
    .size_q   (size_q)
  );

  assign chk_hit     = chk_valid && any_match;
  assign chk_reissue = chk_valid && !chk_branch && !any_match;
  assign chk_recover = chk_valid &&  chk_branch && !any_match;

endmodule

// File: rtl/sltab_chk.sv
module sltab_chk #(
  parameter int N      = 16,
  parameter int REG_W  = 7,
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush_all,
  input logic              ld_valid,
  input logic [REG_W-1:0]  ld_reg,
  input logic              st_valid,
  input logic [ADDR_W-1:0] st_addr,
  input logic [1:0]        st_size,
  input logic              chk_hit,
  input logic              chk_reissue,
  input logic              chk_recover,
  input logic [N-1:0]      alloc_vec,
  input logic [N-1:0]      chk_eq,
  input logic [N-1:0]      v_vec,
  input logic [REG_W-1:0]  reg_q  [N],
  input logic [ADDR_W-1:0] addr_q [N],
  input logic [1:0]        size_q [N]
);
  import sltab_pkg::*;

  logic [REG_W-1:0]  ld_reg_d;
  logic [ADDR_W-1:0] st_addr_d;
  logic [1:0]        st_size_d;
  logic [N-1:0]      alloc_d;
  logic [N-1:0]      reg_seen, stale;

  always_ff @(posedge clk) begin
    ld_reg_d  <= ld_reg;
    st_addr_d <= st_addr;
    st_size_d <= st_size;
    alloc_d   <= alloc_vec;
  end

  function automatic logic meets(input logic [ADDR_W-1:0] a, input logic [1:0] sa,
                                 input logic [ADDR_W-1:0] b, input logic [1:0] sb);
    logic [ADDR_W:0] ae, be;
    ae = {1'b0, a} + (ADDR_W+1)'(span_bytes(sa));
    be = {1'b0, b} + (ADDR_W+1)'(span_bytes(sb));
    return ({1'b0, a} < be) && ({1'b0, b} < ae);
  endfunction

  always_comb begin
    for (int i = 0; i < N; i++) begin
      reg_seen[i] = v_vec[i] && (reg_q[i] == ld_reg_d);
      stale[i]    = v_vec[i] && !alloc_d[i] && meets(addr_q[i], size_q[i], st_addr_d, st_size_d);
    end
  end

  p_one_slot_r7: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(alloc_vec));

  p_reg_unique_r4: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(chk_eq));

  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (v_vec == '0));

  p_load_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !flush_all) |=> (|reg_seen));

  p_store_kills_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> !(|stale));

  p_flag_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({chk_hit, chk_reissue, chk_recover}) <= 1);

endmodule

bind spec_load_table sltab_chk #(.N(ENTRIES), .REG_W(REG_W), .ADDR_W(ADDR_W)) i_sltab_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush_all   (flush_all),
  .ld_valid    (ld_valid),
  .ld_reg      (ld_reg),
  .st_valid    (st_valid),
  .st_addr     (st_addr),
  .st_size     (st_size),
  .chk_hit     (chk_hit),
  .chk_reissue (chk_reissue),
  .chk_recover (chk_recover),
  .alloc_vec   (alloc_vec),
  .chk_eq      (chk_eq),
  .v_vec       (v_vec),
  .reg_q       (reg_q),
  .addr_q      (addr_q),
  .size_q      (size_q)
);

// File: tb/test_spec_load_table.sv
`timescale 1ns/1ps
module test_spec_load_table;

  localparam int NE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_all = 1'b0;
  logic        ld_valid = 1'b0;
  logic [6:0]  ld_reg = '0;
  logic [63:0] ld_addr = '0;
  logic [1:0]  ld_size = '0;
  logic        st_valid = 1'b0;
  logic [63:0] st_addr = '0;
  logic [1:0]  st_size = '0;
  logic        chk_valid = 1'b0;
  logic [6:0]  chk_reg = '0;
  logic        chk_branch = 1'b0;
  logic        chk_clear = 1'b0;
  logic        chk_hit, chk_reissue, chk_recover;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Bench-side model of the table
  bit          m_v    [NE];
  logic [6:0]  m_reg  [NE];
  logic [63:0] m_addr [NE];
  logic [1:0]  m_size [NE];
  int          m_ptr;

  always #2 clk = ~clk;

  spec_load_table i_spec_load_table (
    .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
    .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_addr(ld_addr), .ld_size(ld_size),
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
    .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_branch(chk_branch), .chk_clear(chk_clear),
    .chk_hit(chk_hit), .chk_reissue(chk_reissue), .chk_recover(chk_recover)
  );

  function automatic bit touch(input logic [63:0] a, input logic [1:0] sa,
                               input logic [63:0] b, input logic [1:0] sb);
    logic [64:0] a_end, b_end;
    a_end = 65'(a) + (65'd1 << sa);
    b_end = 65'(b) + (65'd1 << sb);
    return (65'(a) < b_end) && (65'(b) < a_end);
  endfunction

  function automatic bit model_has(input logic [6:0] r);
    for (int i = 0; i < NE; i++) if (m_v[i] && m_reg[i] == r) return 1;
    return 0;
  endfunction

  task automatic model_update();
    bit kill [NE];
    bit live [NE];
    int slot;
    for (int i = 0; i < NE; i++) begin
      kill[i] = m_v[i] && ((st_valid && touch(m_addr[i], m_size[i], st_addr, st_size)) ||
                           (chk_valid && chk_branch && chk_clear && m_reg[i] == chk_reg));
      live[i] = m_v[i] && !kill[i];
    end
    if (flush_all) begin
      for (int i = 0; i < NE; i++) m_v[i] = 0;
      return;
    end
    if (ld_valid) begin
      slot = -1;
      for (int i = 0; i < NE; i++) if (slot < 0 && live[i] && m_reg[i] == ld_reg) slot = i;
      for (int i = 0; i < NE; i++) if (slot < 0 && !live[i]) slot = i;
      if (slot < 0) begin
        slot = m_ptr;
        m_ptr = (m_ptr + 1) % NE;
      end
      live[slot]   = 1;
      m_reg[slot]  = ld_reg;
      m_addr[slot] = ld_addr;
      m_size[slot] = ld_size;
    end
    for (int i = 0; i < NE; i++) m_v[i] = live[i];
  endtask

  // One cycle: drive at negedge, check outputs 1 ns later, advance model
  task automatic cyc(input bit a_v, input logic [6:0] a_r, input logic [63:0] a_a, input logic [1:0] a_s,
                     input bit s_v, input logic [63:0] s_a, input logic [1:0] s_s,
                     input bit c_v, input logic [6:0] c_r, input bit c_b, input bit c_c,
                     input bit fl, input string tag);
    bit eh, er, ec;
    @(negedge clk);
    ld_valid = a_v; ld_reg = a_r; ld_addr = a_a; ld_size = a_s;
    st_valid = s_v; st_addr = s_a; st_size = s_s;
    chk_valid = c_v; chk_reg = c_r; chk_branch = c_b; chk_clear = c_c;
    flush_all = fl;
    #1;
    eh = c_v && model_has(c_r);
    er = c_v && !c_b && !eh;
    ec = c_v &&  c_b && !eh;
    total++;
    if ({chk_hit, chk_reissue, chk_recover} !== {eh, er, ec}) begin
      bad++;
      $display("FAIL %s reg=%0d hit/reissue/recover actual=%b%b%b expected=%b%b%b",
               tag, c_r, chk_hit, chk_reissue, chk_recover, eh, er, ec);
    end
    model_update();
  endtask

  task automatic chk(input logic [6:0] r, input bit br, input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, r, br, 0, 0, tag);
  endtask

  task automatic rec(input logic [6:0] r, input logic [63:0] a, input logic [1:0] s, input string tag);
    cyc(1, r, a, s, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic sto(input logic [63:0] a, input logic [1:0] s, input string tag);
    cyc(0, 0, 0, 0, 1, a, s, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    for (int i = 0; i < NE; i++) begin
      m_v[i] = 0; m_reg[i] = '0; m_addr[i] = '0; m_size[i] = '0;
    end
    m_ptr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 / R3: empty table after reset
    chk(7'd3, 0, "R1 reset load-flavour miss");
    chk(7'd3, 1, "R3 reset branch-flavour miss");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 7'd3, 1, 0, 0, "R3 idle check port");

    // R2 / R10: same-cycle check sees old state
    cyc(1, 7'd10, 64'h100, 2'd3, 0, 0, 0, 1, 7'd10, 0, 0, 0, "R10 same-cycle invisible");
    chk(7'd10, 0, "R2 recorded load hits");
    // R5: byte-range overlap
    sto(64'h108, 2'd0, "R5 adjacent store above");
    chk(7'd10, 0, "R5 adjacent store keeps entry");
    sto(64'h0FE, 2'd1, "R5 adjacent store below");
    chk(7'd10, 0, "R5 touching below keeps entry");
    sto(64'h0FF, 2'd1, "R5 two-byte store straddling start");
    chk(7'd10, 1, "R5 straddling store kills");
    rec(7'd11, 64'hFFFF_FFFF_FFFF_FFF8, 2'd3, "R5 top of space");
    sto(64'h0, 2'd3, "R5 store at zero");
    chk(7'd11, 0, "R5 no wraparound");
    sto(64'hFFFF_FFFF_FFFF_FFFF, 2'd0, "R5 last byte");
    chk(7'd11, 0, "R5 last byte kills");

    // R4: overwrite by same register
    rec(7'd12, 64'h200, 2'd2, "R4 first range");
    rec(7'd12, 64'h300, 2'd2, "R4 second range");
    sto(64'h200, 2'd2, "R4 store old range");
    chk(7'd12, 0, "R4 old range no longer tracked");
    sto(64'h302, 2'd0, "R4 store new range");
    chk(7'd12, 0, "R4 new range killed");

    // R6: store and load same cycle
    cyc(1, 7'd13, 64'h400, 2'd3, 1, 64'h404, 2'd2, 0, 0, 0, 0, 0, "R6 concurrent");
    chk(7'd13, 1, "R6 new entry survives store");

    // R8: clear-on-check
    rec(7'd14, 64'h500, 2'd0, "R8 setup");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 7'd14, 0, 1, 0, "R8 load flavour ignores clear");
    chk(7'd14, 1, "R8 still valid after load-flavour");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 7'd14, 1, 0, 0, "R8 branch hit keep");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 7'd14, 1, 1, 0, "R8 branch hit clear");
    chk(7'd14, 1, "R8 cleared entry misses");

    // R9: flush with concurrent load
    cyc(1, 7'd15, 64'h600, 2'd0, 0, 0, 0, 0, 0, 0, 0, 1, "R9 flush");
    chk(7'd15, 0, "R9 concurrent load discarded");
    chk(7'd13, 0, "R9 older entry flushed");

    // R7: fill past capacity, twice, to move the pointer
    for (int k = 0; k < 2 * NE + 3; k++) rec(7'(40 + k), 64'h800 + 64'(8 * k), 2'd3, "R7 fill");
    for (int k = 0; k < 2 * NE + 3; k++) chk(7'(40 + k), k[0], "R7 after eviction");

    // Constrained random
    void'($urandom(32'd2468));
    for (int n = 0; n < 4000; n++) begin
      bit a_v, s_v, c_v, fl;
      a_v = ($urandom % 3) == 0;
      s_v = ($urandom % 3) == 0;
      c_v = ($urandom % 2) == 0;
      fl  = ($urandom % 97) == 0;
      cyc(a_v, 7'($urandom % 24), 64'h1000 + 64'($urandom % 64), 2'($urandom),
          s_v, 64'h1000 + 64'($urandom % 64), 2'($urandom),
          c_v, 7'($urandom % 24), 1'($urandom), 1'($urandom), fl, "R2 R4 R5 R7 R8 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule